// File: doc/BRIEF.md
# PHY Error Statistics and LED Routing Register Bank

This block is a small management register bank for a physical-layer device. It keeps three 16-bit statistics counters. Each one is fed by a single-cycle event pulse from a different part of the line interface: early frame termination on the 100 Mb/s receiver, frame-end errors on the 10 Mb/s receiver, and jabber on the 10 Mb/s transmitter. The counters stop at all ones instead of wrapping, and a read of a counter clears it. A management agent can therefore poll them without losing events and without seeing a wrapped count.

The bank also holds a spare 16-bit scratch register and an LED routing register. The low three bits of the routing register choose which live link-state signal, or which constant level, drives each of the two LED pins. All registers share one synchronous access port made of a 5-bit address, a read strobe and a write strobe. This port carries no stream data, so it has no valid/ready handshake and never applies back-pressure: every strobe is accepted in the cycle it is asserted. Read data is registered and holds its value until the next read.

Top module: `phy_stat_bank`

## Requirements
- R1: Counters sit at address 23 (100 Mb/s early frame end), address 24 (10 Mb/s frame-end error) and address 25 (jabber). Each counter goes up by one for every cycle its own event input is high, and events on one input leave the other two counters unchanged.
- R2: A counter that holds 0xFFFF keeps 0xFFFF when further events arrive.
- R3: A read of a counter returns its current value and leaves the counter at zero.
- R4: A write to addresses 23, 24 or 25 does not change the counter at that address.
- R5: If an event and a read of the same counter fall in the same cycle, the read returns the value from before that event and the counter is left at 1.
- R6: Address 26 stores all 16 bits written to it and returns them on a read.
- R7: At address 27, bits 2:0 are a writable LED select code and bits 15:3 always read as zero, whatever value was written.
- R8: The LED pins follow the select code, written as code → (led_act, led_li): 000 → (activity, link), 001 → (speed, collision), 010 → (speed, link), 011 → (activity, collision), 100 → (0, 0), 101 → (0, 1), 110 → (1, 0), 111 → (1, 1). The pins are combinational from the code and the status inputs.
- R9: A read of any address other than 23 to 27 returns 0x0000. A write to such an address changes no register.
- R10: While reset is high at a clock edge, all counters, both writable registers and the read data go to zero.
- R11: Read data appears on reg_rdata in the cycle after the clock edge that samples reg_rd, and it holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 5 | Register address |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| evt_fx_eof | input | 1 | Early frame end pulse, 100 Mb/s receive |
| evt_tp_eof | input | 1 | Frame-end error pulse, 10 Mb/s receive |
| evt_jabber | input | 1 | Jabber pulse, 10 Mb/s transmit |
| st_activity | input | 1 | Activity status |
| st_speed | input | 1 | Speed status |
| st_link | input | 1 | Link status |
| st_collision | input | 1 | Collision status |
| led_act | output | 1 | First LED pin |
| led_li | output | 1 | Second LED pin |

## Verification
The assertions assume that the address is stable and valid whenever a strobe is high. They also assume that read and write are not asserted together and that event inputs are known after reset. The stimulus meets these assumptions by changing inputs only on the falling clock edge, by raising one strobe at a time and by driving every event input to a defined level on every cycle. The saturation property counts on the counter having reached 0xFFFF through real events. The bench therefore drives all three event inputs for more than 65 535 consecutive cycles instead of forcing that state.

// File: rtl/phy_stat_pkg.sv
package phy_stat_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 16;
  localparam int NUM_CNT = 3;
  localparam logic [ADDR_W-1:0] ADDR_CNT_BASE = 5'd23;
  localparam logic [ADDR_W-1:0] ADDR_SPARE    = 5'd26;
  localparam logic [ADDR_W-1:0] ADDR_LEDSEL   = 5'd27;
  localparam int LEDSEL_W = 3;

  typedef enum logic [LEDSEL_W-1:0] {
    LED_ACT_LINK  = 3'b000,
    LED_SPD_COL   = 3'b001,
    LED_SPD_LINK  = 3'b010,
    LED_ACT_COL   = 3'b011,
    LED_OFF_OFF   = 3'b100,
    LED_OFF_ON    = 3'b101,
    LED_ON_OFF    = 3'b110,
    LED_ON_ON     = 3'b111
  } led_sel_e;
endpackage

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         evt,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] MAX = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (clr)
      cnt <= evt ? W'(1) : '0;
    else if (evt && cnt != MAX)
      cnt <= cnt + W'(1);
  end

  assert_inc_R1: assert property (@(posedge clk) disable iff (rst)
    (!clr && evt && cnt != MAX) |=> cnt == $past(cnt) + W'(1));
  assert_idle_R1: assert property (@(posedge clk) disable iff (rst)
    (!clr && !evt) |=> $stable(cnt));
  assert_sat_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!clr && cnt == MAX) |=> cnt == MAX);
  assert_rd_clear_R3: assert property (@(posedge clk) disable iff (rst)
    (clr && !evt) |=> cnt == '0);
  assert_rd_evt_R5: assert property (@(posedge clk) disable iff (rst)
    (clr && evt) |=> cnt == W'(1));
endmodule

// File: rtl/led_router.sv
module led_router
  import phy_stat_pkg::*;
(
  input  logic [LEDSEL_W-1:0] sel,
  input  logic                activity,
  input  logic                speed,
  input  logic                link,
  input  logic                collision,
  output logic                act,
  output logic                li
);
  always_comb begin
    unique case (led_sel_e'(sel))
      LED_ACT_LINK: begin act = activity; li = link;      end
      LED_SPD_COL:  begin act = speed;    li = collision; end
      LED_SPD_LINK: begin act = speed;    li = link;      end
      LED_ACT_COL:  begin act = activity; li = collision; end
      LED_OFF_OFF:  begin act = 1'b0;     li = 1'b0;      end
      LED_OFF_ON:   begin act = 1'b0;     li = 1'b1;      end
      LED_ON_OFF:   begin act = 1'b1;     li = 1'b0;      end
      default:      begin act = 1'b1;     li = 1'b1;      end
    endcase
  end
endmodule

// File: rtl/phy_stat_bank.sv
module phy_stat_bank
  import phy_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              evt_fx_eof,
  input  logic              evt_tp_eof,
  input  logic              evt_jabber,
  input  logic              st_activity,
  input  logic              st_speed,
  input  logic              st_link,
  input  logic              st_collision,
  output logic              led_act,
  output logic              led_li
);
  logic [NUM_CNT-1:0] evt_vec;
  logic [NUM_CNT-1:0] clr_vec;
  logic [DATA_W-1:0]  cnt_arr [NUM_CNT];
  logic [DATA_W-1:0]  spare_q;
  logic [LEDSEL_W-1:0] ledsel_q;
  logic [DATA_W-1:0]  rd_mux;

  assign evt_vec = {evt_jabber, evt_tp_eof, evt_fx_eof};

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_CNT_BASE + ADDR_W'(g);
    assign clr_vec[g] = reg_rd && (reg_addr == MY_ADDR);
    sat_counter #(.W(DATA_W)) u_cnt (
      .clk (clk),
      .rst (rst),
      .evt (evt_vec[g]),
      .clr (clr_vec[g]),
      .cnt (cnt_arr[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      spare_q  <= '0;
      ledsel_q <= '0;
    end else if (reg_wr) begin
      if (reg_addr == ADDR_SPARE)  spare_q  <= reg_wdata;
      if (reg_addr == ADDR_LEDSEL) ledsel_q <= reg_wdata[LEDSEL_W-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_CNT; i++)
      if (reg_addr == ADDR_CNT_BASE + ADDR_W'(i)) rd_mux = cnt_arr[i];
    if (reg_addr == ADDR_SPARE)  rd_mux = spare_q;
    if (reg_addr == ADDR_LEDSEL) rd_mux = {{(DATA_W-LEDSEL_W){1'b0}}, ledsel_q};
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

  led_router u_led (
    .sel       (ledsel_q),
    .activity  (st_activity),
    .speed     (st_speed),
    .link      (st_link),
    .collision (st_collision),
    .act       (led_act),
    .li        (led_li)
  );

  logic addr_impl;
  assign addr_impl = (reg_addr >= ADDR_CNT_BASE) && (reg_addr <= ADDR_LEDSEL);

  assert_unimpl_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && !addr_impl) |=> reg_rdata == '0);
  assert_resv_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == ADDR_LEDSEL) |=> reg_rdata[DATA_W-1:LEDSEL_W] == '0);
  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> $stable(reg_rdata));
  assert_spare_ret_R6: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == ADDR_SPARE) |=> reg_rdata == $past(spare_q));
  assert_led_const_R8: assert property (@(posedge clk) disable iff (rst)
    ledsel_q[2] |-> (led_act == ledsel_q[1] && led_li == ledsel_q[0]));
endmodule

// File: tb/phy_stat_bank_tb.sv
module phy_stat_bank_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [4:0] reg_addr = '0;
  logic reg_rd = 1'b0, reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic evt_fx_eof = 0, evt_tp_eof = 0, evt_jabber = 0;
  logic st_activity = 0, st_speed = 0, st_link = 0, st_collision = 0;
  logic led_act, led_li;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  phy_stat_bank u_dut (.*);

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1;
    @(posedge clk); #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] v);
    @(negedge clk); reg_addr = a; reg_wdata = v; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic pulse(int a, int b, int c);
    int m = (a > b) ? a : b;
    if (c > m) m = c;
    for (int i = 0; i < m; i++) begin
      @(negedge clk);
      evt_fx_eof = (i < a); evt_tp_eof = (i < b); evt_jabber = (i < c);
    end
    @(negedge clk); evt_fx_eof = 0; evt_tp_eof = 0; evt_jabber = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst = 0;
    // R10 reset state
    check("R10 rdata", reg_rdata, 16'h0);
    check("R10 led", {14'h0, led_act, led_li}, {14'h0, st_activity, st_link});
    for (int a = 23; a <= 27; a++) begin
      rd(5'(a), d); check("R10 reg", d, 16'h0);
    end
    // R1/R3 counting with distinct patterns
    for (int t = 1; t <= 6; t++) begin
      int a = t * 3, b = t * 5 + 1, c = (t * 7) % 11;
      pulse(a, b, c);
      rd(5'd23, d); check("R1 fx", d, 16'(a));
      rd(5'd24, d); check("R1 tp", d, 16'(b));
      rd(5'd25, d); check("R1 jab", d, 16'(c));
      for (int k = 23; k <= 25; k++) begin
        rd(5'(k), d); check("R3 clear", d, 16'h0);
      end
    end
    // R11 hold
    @(negedge clk); @(negedge clk);
    check("R11 hold", reg_rdata, 16'h0);
    // R4 writes to counters ignored
    pulse(3, 4, 5);
    wr(5'd23, 16'h1234); wr(5'd24, 16'hFFFF); wr(5'd25, 16'h0);
    rd(5'd23, d); check("R4 fx", d, 16'd3);
    rd(5'd24, d); check("R4 tp", d, 16'd4);
    rd(5'd25, d); check("R4 jab", d, 16'd5);
    // R5 event with read
    pulse(5, 0, 0);
    @(negedge clk); reg_addr = 5'd23; reg_rd = 1; evt_fx_eof = 1;
    @(posedge clk); #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0; evt_fx_eof = 0;
    check("R5 old", d, 16'd5);
    rd(5'd23, d); check("R5 one", d, 16'd1);
    // R6 spare register
    for (int p = 0; p < 16; p++) begin
      logic [15:0] v = 16'(1 << p) ^ 16'(p * 16'h0F0F);
      wr(5'd26, v); rd(5'd26, d); check("R6 spare", d, v);
    end
    // R7 select register and reserved bits
    wr(5'd27, 16'hFFFD); rd(5'd27, d); check("R7 resv", d, 16'h0005);
    // R8 exhaustive LED mapping
    for (int code = 0; code < 8; code++) begin
      wr(5'd27, 16'(code));
      for (int s = 0; s < 16; s++) begin
        logic ea, el;
        @(negedge clk);
        {st_activity, st_speed, st_link, st_collision} = 4'(s);
        #1;
        case (code)
          0: begin ea = st_activity; el = st_link; end
          1: begin ea = st_speed; el = st_collision; end
          2: begin ea = st_speed; el = st_link; end
          3: begin ea = st_activity; el = st_collision; end
          default: begin ea = code[1]; el = code[0]; end
        endcase
        check("R8 led", {14'h0, led_act, led_li}, {14'h0, ea, el});
      end
    end
    // R9 unimplemented addresses
    wr(5'd26, 16'hA5C3); wr(5'd27, 16'h0002);
    for (int a = 0; a < 32; a++) begin
      if (a < 23 || a > 27) begin
        wr(5'(a), 16'hFFFF); rd(5'(a), d); check("R9 unimpl", d, 16'h0);
      end
    end
    rd(5'd26, d); check("R9 spare kept", d, 16'hA5C3);
    rd(5'd27, d); check("R9 sel kept", d, 16'h0002);
    // R2 saturation
    pulse(65540, 65540, 65540);
    rd(5'd23, d); check("R2 fx", d, 16'hFFFF);
    rd(5'd24, d); check("R2 tp", d, 16'hFFFF);
    rd(5'd25, d); check("R2 jab", d, 16'hFFFF);
    rd(5'd23, d); check("R2 cleared", d, 16'h0);
    // R10 reset mid-run
    pulse(2, 2, 2);
    @(negedge clk); rst = 1; @(negedge clk); rst = 0;
    check("R10 rdata", reg_rdata, 16'h0);
    rd(5'd24, d); check("R10 cnt", d, 16'h0);
    rd(5'd26, d); check("R10 spare", d, 16'h0);
    rd(5'd27, d); check("R10 sel", d, 16'h0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule